// File: doc/BRIEF.md
# I2C Line Recovery Controller

This block lets software seize the clock and data wires of an I2C bus when a device has wedged the bus, typically by holding data low in the middle of a byte. It has a small register window with two registers. The first holds a persistent soft-reset bit. While that bit is set, the block keeps the I2C protocol engine in reset and hands both pads to software. The second register holds two drive bits that set the level each open-drain pad tries to produce. It also holds two read-back bits that show the level actually present on each wire. Software compares the read-back bits with the drive bits to learn whether the bus obeyed. If the data line stays low, software pulses the clock bit until the line is released.

When the soft-reset bit is clear, the protocol engine's own pull-down enables go straight to the pads and the drive bits have no effect. The pads are open-drain: a pull-down enable of 1 pulls the wire low, and 0 lets it float high. The read-back bits pass through a two-stage synchronizer before software can see them.

Top module: `i2c_line_recovery`

## Requirements
- R1: After hard reset (`rst_n` low), the soft-reset bit is 0. Both drive bits and both read-back bits read 1, so address 1 reads 0x0F. Both pad enables follow the engine inputs.
- R2: Writing 1 to bit 0 of address 0 sets the soft-reset bit. It then stays 1, with `eng_rst_o` high, until it is cleared as described in R3.
- R3: The soft-reset bit is cleared by writing 0 to bit 0 of address 0, by `ext_rst_i`, or by a hard reset. If `ext_rst_i` and a write of 1 arrive in the same cycle, `ext_rst_i` wins and the bit ends at 0.
- R4: `eng_rst_o` is high whenever the soft-reset bit is 1, `ext_rst_i` is 1, or `rst_n` is 0, and is low otherwise.
- R5: While the soft-reset bit is 1, `scl_oe_o` is the inverse of bit 0 of address 1 (clock drive) and `sda_oe_o` is the inverse of bit 1 (data drive).
- R6: While the soft-reset bit is 0, `scl_oe_o` equals `eng_scl_oe_i`, `sda_oe_o` equals `eng_sda_oe_i`, and the drive bits are ignored.
- R7: The drive bits change only on a write to address 1 or a hard reset. Setting or clearing the soft-reset bit leaves them unchanged, and so does `ext_rst_i`.
- R8: Bit 2 of address 1 shows `scl_in_i` and bit 3 shows `sda_in_i`, each delayed by two clock edges. Writes to bits 2 and 3 are ignored.
- R9: Address 0 bits 7:1 read 0, address 1 bits 7:4 read 0, and addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| ext_rst_i | input | 1 | External I2C reset request, active high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (2) | Register address |
| wdata_i | input | DATA_W (8) | Write data |
| rdata_o | output | DATA_W (8) | Read data for `addr_i`, combinational |
| scl_in_i | input | 1 | Clock wire level from pad |
| sda_in_i | input | 1 | Data wire level from pad |
| eng_scl_oe_i | input | 1 | Engine clock pull-down enable |
| eng_sda_oe_i | input | 1 | Engine data pull-down enable |
| scl_oe_o | output | 1 | Clock pad pull-down enable |
| sda_oe_o | output | 1 | Data pad pull-down enable |
| eng_rst_o | output | 1 | Reset to the protocol engine, active high |

## Verification
The assertions assume that `wr_en_i`, `addr_i`, `wdata_i` and `ext_rst_i` are synchronous to `clk` and hold steady around each rising edge. They also assume the engine enables change only between edges. The pad inputs are treated as asynchronous, and the synchronizer check only requires agreement after an input has held still for two samples. The bench changes every input at the falling edge. It models the bus as a wired-AND of the block's own pull-downs and an extra pull-down standing for a stuck device, so the wire levels it feeds back are always ones the pads could produce.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

    // Register addresses
    localparam int unsigned CTRL_ADDR = 0;
    localparam int unsigned LINE_ADDR = 1;

    // Bit positions inside the line register
    localparam int unsigned LINE_SCL_DRV  = 0;
    localparam int unsigned LINE_SDA_DRV  = 1;
    localparam int unsigned LINE_SCL_SEEN = 2;
    localparam int unsigned LINE_SDA_SEEN = 3;

    // Bit position of the soft-reset flag in the control register
    localparam int unsigned CTRL_SRST = 0;

    // Synchronizer lane order
    localparam int unsigned LANE_SCL = 0;
    localparam int unsigned LANE_SDA = 1;
    localparam int unsigned LANES    = 2;

    typedef struct packed {
        logic srst;
        logic scl_drv;
        logic sda_drv;
    } rcv_state_t;

    localparam rcv_state_t RCV_RESET = '{srst: 1'b0, scl_drv: 1'b1, sda_drv: 1'b1};

endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
    parameter int unsigned   W      = 2,
    parameter int unsigned   STAGES = 2,
    parameter logic [W-1:0]  INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    localparam int unsigned CNT_W = $clog2(STAGES + 1);

    for (genvar g = 0; g < W; g++) begin : g_lane
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{INIT[g]}};
            else        chain_q <= chain_d;
        end

        assign sync_o[g] = chain_q[STAGES-1];

        // Settle tracker for the latency check below
        logic             prev_d, prev_q;
        logic [CNT_W-1:0] hold_d, hold_q;

        always_comb begin
            prev_d = async_i[g];
            hold_d = hold_q;
            if (async_i[g] != prev_q)             hold_d = '0;
            else if (hold_q < CNT_W'(STAGES))     hold_d = hold_q + 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= INIT[g];
                hold_q <= '0;
            end else begin
                prev_q <= prev_d;
                hold_q <= hold_d;
            end
        end

        // R8: a level held for STAGES samples has reached the output
        assert_sync_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_q == CNT_W'(STAGES)) |-> (sync_o[g] == prev_q));
    end

endmodule

// File: rtl/i2c_rcv_regs.sv
module i2c_rcv_regs
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [LANES-1:0]  seen_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              srst_o,
    output logic              scl_drv_o,
    output logic              sda_drv_o
);

    rcv_state_t st_d, st_q;

    logic ctrl_wr, line_wr;
    assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR));
    assign line_wr = wr_en_i && (addr_i == ADDR_W'(LINE_ADDR));

    // Upper write-data bits carry no field
    logic unused_wbits;
    assign unused_wbits = ^wdata_i[DATA_W-1:LINE_SCL_SEEN];

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) st_d.srst = wdata_i[CTRL_SRST];
        if (line_wr) begin
            st_d.scl_drv = wdata_i[LINE_SCL_DRV];
            st_d.sda_drv = wdata_i[LINE_SDA_DRV];
        end
        if (ext_rst_i) st_d.srst = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RCV_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(CTRL_ADDR)) begin
            rdata_o[CTRL_SRST] = st_q.srst;
        end else if (addr_i == ADDR_W'(LINE_ADDR)) begin
            rdata_o[LINE_SCL_DRV]  = st_q.scl_drv;
            rdata_o[LINE_SDA_DRV]  = st_q.sda_drv;
            rdata_o[LINE_SCL_SEEN] = seen_i[LANE_SCL];
            rdata_o[LINE_SDA_SEEN] = seen_i[LANE_SDA];
        end
    end

    assign srst_o    = st_q.srst;
    assign scl_drv_o = st_q.scl_drv;
    assign sda_drv_o = st_q.sda_drv;

    assert_srst_persist_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.srst && !ctrl_wr && !ext_rst_i) |=> st_q.srst);

    assert_ext_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_i |=> !st_q.srst);

    assert_drv_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !line_wr |=> ($stable(st_q.scl_drv) && $stable(st_q.sda_drv)));

endmodule

// File: rtl/i2c_rcv_padmux.sv
module i2c_rcv_padmux
    import i2c_rcv_pkg::*;
(
    input  logic             manual_i,
    input  logic [LANES-1:0] drv_i,
    input  logic [LANES-1:0] eng_oe_i,
    output logic [LANES-1:0] pad_oe_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_pad
        always_comb begin
            if (manual_i) pad_oe_o[g] = ~drv_i[g];
            else          pad_oe_o[g] = eng_oe_i[g];
        end
    end

endmodule

// File: rtl/i2c_line_recovery.sv
module i2c_line_recovery
    import i2c_rcv_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              scl_in_i,
    input  logic              sda_in_i,
    input  logic              eng_scl_oe_i,
    input  logic              eng_sda_oe_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              eng_rst_o
);

    logic [LANES-1:0] pad_raw, pad_seen, drv_bits, eng_oe, pad_oe;
    logic             srst, scl_drv, sda_drv;

    assign pad_raw[LANE_SCL] = scl_in_i;
    assign pad_raw[LANE_SDA] = sda_in_i;

    i2c_rcv_sync #(
        .W      (LANES),
        .STAGES (SYNC_STAGES),
        .INIT   ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_raw),
        .sync_o  (pad_seen)
    );

    i2c_rcv_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_rst_i (ext_rst_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .seen_i    (pad_seen),
        .rdata_o   (rdata_o),
        .srst_o    (srst),
        .scl_drv_o (scl_drv),
        .sda_drv_o (sda_drv)
    );

    assign drv_bits[LANE_SCL] = scl_drv;
    assign drv_bits[LANE_SDA] = sda_drv;
    assign eng_oe[LANE_SCL]   = eng_scl_oe_i;
    assign eng_oe[LANE_SDA]   = eng_sda_oe_i;

    i2c_rcv_padmux u_pad (
        .manual_i (srst),
        .drv_i    (drv_bits),
        .eng_oe_i (eng_oe),
        .pad_oe_o (pad_oe)
    );

    assign scl_oe_o  = pad_oe[LANE_SCL];
    assign sda_oe_o  = pad_oe[LANE_SDA];
    assign eng_rst_o = srst | ext_rst_i | ~rst_n;

    logic ctrl_wr;
    assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_ADDR));

    assert_eng_rst_after_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wdata_i[CTRL_SRST] && !ext_rst_i) |=> eng_rst_o);

    assert_manual_pads_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (srst && !wr_en_i && !ext_rst_i) |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

    assert_engine_owns_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && !wr_en_i) |=> (scl_oe_o == eng_scl_oe_i && sda_oe_o == eng_sda_oe_i));

endmodule

// File: tb/tb_i2c_line_recovery.sv
module tb_i2c_line_recovery;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       eng_scl = 1'b0, eng_sda = 1'b0;
    logic       stuck_scl = 1'b0, stuck_sda = 1'b0;
    logic       scl_oe, sda_oe, eng_rst;
    logic       scl_pad, sda_pad;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    // Wired-AND bus: our pull-down plus an external stuck device
    assign scl_pad = ~(scl_oe | stuck_scl);
    assign sda_pad = ~(sda_oe | stuck_sda);

    i2c_line_recovery dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_rst_i    (ext_rst),
        .wr_en_i      (wr_en),
        .addr_i       (addr),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .scl_in_i     (scl_pad),
        .sda_in_i     (sda_pad),
        .eng_scl_oe_i (eng_scl),
        .eng_sda_oe_i (eng_sda),
        .scl_oe_o     (scl_oe),
        .sda_oe_o     (sda_oe),
        .eng_rst_o    (eng_rst)
    );

    // Reference model
    bit m_srst = 0, m_scl_drv = 1, m_sda_drv = 1;
    bit m_scl_seen = 1, m_sda_seen = 1;
    bit scl_pipe[$] = '{1'b1};
    bit sda_pipe[$] = '{1'b1};

    function automatic bit exp_scl_oe();
        return m_srst ? !m_scl_drv : eng_scl;
    endfunction
    function automatic bit exp_sda_oe();
        return m_srst ? !m_sda_drv : eng_sda;
    endfunction
    function automatic int exp_rdata();
        if (addr == 2'd0) return int'(m_srst);
        if (addr == 2'd1) return int'({m_sda_seen, m_scl_seen, m_sda_drv, m_scl_drv});
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_srst = 0; m_scl_drv = 1; m_sda_drv = 1;
            m_scl_seen = 1; m_sda_seen = 1;
            scl_pipe = '{1'b1}; sda_pipe = '{1'b1};
        end else begin
            bit pscl, psda;
            pscl = !(exp_scl_oe() | stuck_scl);
            psda = !(exp_sda_oe() | stuck_sda);
            scl_pipe.push_back(pscl);
            sda_pipe.push_back(psda);
            m_scl_seen = scl_pipe.pop_front();
            m_sda_seen = sda_pipe.pop_front();
            if (wr_en && addr == 2'd0) m_srst = wdata[0];
            if (wr_en && addr == 2'd1) begin
                m_scl_drv = wdata[0];
                m_sda_drv = wdata[1];
            end
            if (ext_rst) m_srst = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(addr == 2'd1 ? "R8 rdata" : "R2 rdata", int'(rdata), exp_rdata());
        chk(m_srst ? "R5 scl_oe" : "R6 scl_oe", int'(scl_oe), int'(exp_scl_oe()));
        chk(m_srst ? "R5 sda_oe" : "R6 sda_oe", int'(sda_oe), int'(exp_sda_oe()));
        chk("R4 eng_rst", int'(eng_rst), int'(m_srst | ext_rst | !rst_n));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; addr = 2'(a); wdata = 8'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1; addr = 2'd1;
        tick();
        chk("R1 line reset", int'(rdata), 8'h0F);
        chk("R1 oe follow engine", int'({scl_oe, sda_oe}), 0);
        addr = 2'd0;
        tick();
        chk("R1 srst reset", int'(rdata), 0);

        // Engine ownership, drive bits ignored
        for (int i = 0; i < 4; i++) begin
            eng_scl = i[0]; eng_sda = i[1];
            tick();
            chk("R6 engine scl", int'(scl_oe), i & 1);
        end
        eng_scl = 1'b1; eng_sda = 1'b0;
        wr(1, 8'h00);
        tick();
        chk("R6 drive ignored", int'({scl_oe, sda_oe}), 2);
        addr = 2'd1;
        tick(); tick();
        chk("R8 scl seen low", int'(rdata[2]), 0);

        // Manual control
        eng_scl = 1'b0; eng_sda = 1'b0;
        wr(0, 8'h01);
        chk("R2 eng_rst on", int'(eng_rst), 1);
        chk("R5 both pulled", int'({scl_oe, sda_oe}), 3);
        addr = 2'd0;
        repeat (5) tick();
        chk("R2 persists", int'(rdata), 1);
        for (int i = 0; i < 4; i++) begin
            eng_scl = i[1]; eng_sda = i[0];
            wr(1, i);
            chk("R5 scl from drive", int'(scl_oe), int'(!i[0]));
            chk("R5 sda from drive", int'(sda_oe), int'(!i[1]));
        end
        wr(1, 8'h01);
        addr = 2'd1;
        tick(); tick();
        chk("R8 readback follows", int'(rdata), 8'h05);
        stuck_scl = 1'b1;
        tick(); tick();
        chk("R8 stuck clock seen", int'(rdata), 8'h01);
        stuck_scl = 1'b0;
        wr(1, 8'h0E);
        tick(); tick(); tick();
        chk("R8 seen write ignored", int'(rdata), 8'h0A);

        // Address map
        wr(0, 8'hFF);
        addr = 2'd0; tick();
        chk("R9 ctrl upper zero", int'(rdata), 1);
        addr = 2'd2; tick();
        chk("R9 addr2 zero", int'(rdata), 0);
        addr = 2'd3; tick();
        chk("R9 addr3 zero", int'(rdata), 0);
        wr(1, 8'hF2);
        addr = 2'd1; tick();
        chk("R9 line upper zero", int'(rdata[7:4]), 4'hF & 4'b0000);

        // Clearing paths
        wr(0, 8'h00);
        chk("R3 cleared by write", int'(eng_rst), 0);
        addr = 2'd1; tick();
        chk("R7 drive kept on clear", int'(rdata[1:0]), 2);
        wr(0, 8'h01);
        ext_rst = 1'b1;
        tick();
        chk("R4 ext drives eng_rst", int'(eng_rst), 1);
        ext_rst = 1'b0;
        addr = 2'd0; tick();
        chk("R3 ext clears", int'(rdata), 0);
        addr = 2'd1; tick();
        chk("R7 drive kept on ext", int'(rdata[1:0]), 2);
        ext_rst = 1'b1;
        wr(0, 8'h01);
        ext_rst = 1'b0;
        tick();
        chk("R3 ext beats write", int'(eng_rst), 0);

        // Hard reset mid-run
        wr(0, 8'h01);
        rst_n = 1'b0;
        tick();
        chk("R4 hard reset eng_rst", int'(eng_rst), 1);
        rst_n = 1'b1;
        addr = 2'd1;
        tick();
        chk("R1 line after reset", int'(rdata), 8'h0F);
        addr = 2'd0; tick();
        chk("R1 srst after reset", int'(rdata), 0);

        report();
    end

endmodule